// File: doc/BRIEF.md
# Commit-Stage Redirect and Instruction-Fence Controller

This block sits beside the commit point of an out-of-order core and decides, one cycle after an event retires, whether the front end must refetch and from which address. Four kinds of event can arrive: a trap raised by the committing instruction, a memory-ordering violation that forces the instruction to be replayed, a branch that resolved against its prediction, and an instruction-fence. The block picks one winner per cycle, registers it, and drives a single-cycle recover pulse with the matching restart address. An instruction-fence restarts at the address after the fence and, in the same registered cycle, flushes the instruction cache.

The block also holds the valid bits and tags of a small direct-indexed instruction cache. The fence-driven flush, the invalidate requests from the memory side and line fills all act on it, and a lookup port reports hits. The arbitration between these updates and the fence timing can then be observed directly.

All pins are plain control and data pins sampled on every clock. There is no valid/ready stream at the edge. The only back-pressure is the store-commit stall input. While it is high, a fence is held off, and the commit logic is expected to present the fence again later.

Top module: `commit_redirect_ctrl`

## Requirements
- R1: After reset, `recover_o` and `icflush_o` are 0 and every lookup reports a miss.
- R2: `recover_o` rises in the cycle after an accepted event and falls the following cycle unless a new event was accepted, so each event gives a one-cycle pulse.
- R3: When several events arrive in one cycle, only one wins, in this order: trap first, then ordering violation, then misprediction, then fence. The restart address is the winner's.
- R4: A winning misprediction gives `recover_pc_o` equal to the branch target presented with it.
- R5: A winning ordering violation gives `recover_pc_o` equal to `commit_pc_i`, so the instruction is refetched.
- R6: A winning trap gives `recover_pc_o` equal to `exc_vec_i`. A trap arriving in the cycle its predecessor's pulse is out is still captured, with its own address.
- R7: A fence with `st_stall_i` low gives a recover pulse to `commit_npc_i`, with `icflush_o` high in that same cycle. A fence with `st_stall_i` high has no effect on `recover_o`, `icflush_o` or the cache lines.
- R8: In the cycle after `icflush_o` is high, every line is invalid. This holds even when a fill was presented in the flush cycle.
- R9: An invalidate clears the indexed line. If an invalidate and a fill target the same line in the same cycle, the invalidate wins.
- R10: A fill marks its line valid and stores its tag. A lookup hits only when the line is valid and the stored tag equals `lookup_tag_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_i | input | 1 | Committing instruction raises a trap |
| exc_vec_i | input | PC_W | Trap handler address |
| viol_i | input | 1 | Load/store ordering violation at commit |
| commit_pc_i | input | PC_W | Address of the committing instruction |
| commit_npc_i | input | PC_W | Address following the committing instruction |
| mispred_i | input | 1 | Committing branch was mispredicted |
| mispred_target_i | input | PC_W | Resolved branch target |
| fence_i | input | 1 | Committing instruction is an instruction-fence |
| st_stall_i | input | 1 | Store commit stalled; holds off a fence |
| recover_o | output | 1 | Registered front-end redirect pulse |
| recover_pc_o | output | PC_W | Restart address while `recover_o` is high |
| icflush_o | output | 1 | Instruction-cache flush pulse |
| fill_i | input | 1 | Write a line into the cache |
| fill_idx_i | input | IDX_W | Line index of the fill |
| fill_tag_i | input | TAG_W | Tag of the fill |
| inval_i | input | 1 | Invalidate one line |
| inval_idx_i | input | IDX_W | Line index to invalidate |
| lookup_idx_i | input | IDX_W | Line index to look up |
| lookup_tag_i | input | TAG_W | Tag to compare |
| lookup_hit_o | output | 1 | Lookup hit (combinational) |

## Verification
Several pairs of functions can act in the same cycle. A trap can arrive while the pulse of an earlier trap is on the outputs. A fill can land in the cycle the fence's flush takes effect. An invalidate and a fill can name one line. The bench provokes each by driving both inputs on one falling edge. A scoreboard of predicted pulses and addresses judges the redirect side. Lookups made just before and just after the flush edge judge the cache side, and show that the flush wins one cycle later than the fence pulse.

// File: rtl/redir_pkg.sv
package redir_pkg;
  typedef enum logic [2:0] {
    RC_NONE  = 3'd0,
    RC_TRAP  = 3'd1,
    RC_VIOL  = 3'd2,
    RC_MISP  = 3'd3,
    RC_FENCE = 3'd4
  } rcause_e;
endpackage

// File: rtl/redir_arbiter.sv
module redir_arbiter
  import redir_pkg::*;
(
  input  logic    exc_i,
  input  logic    viol_i,
  input  logic    mispred_i,
  input  logic    fence_i,
  input  logic    st_stall_i,
  output rcause_e cause_o
);
  // Fixed priority; the trap is tested first so a fresh trap always lands.
  always_comb begin
    if (exc_i)                     cause_o = RC_TRAP;
    else if (viol_i)               cause_o = RC_VIOL;
    else if (mispred_i)            cause_o = RC_MISP;
    else if (fence_i && !st_stall_i) cause_o = RC_FENCE;
    else                           cause_o = RC_NONE;
  end
endmodule

// File: rtl/redir_regs.sv
module redir_regs
  import redir_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rcause_e         cause_i,
  input  logic [PC_W-1:0] exc_vec_i,
  input  logic [PC_W-1:0] commit_pc_i,
  input  logic [PC_W-1:0] commit_npc_i,
  input  logic [PC_W-1:0] target_i,
  output logic            recover_o,
  output logic [PC_W-1:0] recover_pc_o,
  output logic            flush_o
);
  logic            trap_q, viol_q, misp_q, fence_q;
  logic [PC_W-1:0] hold_pc_q, tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q    <= 1'b0;
      viol_q    <= 1'b0;
      misp_q    <= 1'b0;
      fence_q   <= 1'b0;
      hold_pc_q <= '0;
      tgt_q     <= '0;
    end else begin
      trap_q  <= (cause_i == RC_TRAP);
      viol_q  <= (cause_i == RC_VIOL);
      misp_q  <= (cause_i == RC_MISP);
      fence_q <= (cause_i == RC_FENCE);
      case (cause_i)
        RC_TRAP:  hold_pc_q <= exc_vec_i;
        RC_VIOL:  hold_pc_q <= commit_pc_i;
        RC_FENCE: hold_pc_q <= commit_npc_i;
        RC_MISP:  tgt_q     <= target_i;
        default:  ;
      endcase
    end
  end

  assign recover_o    = trap_q | viol_q | misp_q | fence_q;
  assign recover_pc_o = misp_q ? tgt_q : hold_pc_q;
  assign flush_o      = fence_q;

  // R3: at most one registered cause at a time
  a_r3_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_q, viol_q, misp_q, fence_q}));
endmodule

// File: rtl/icache_valid_tags.sv
module icache_valid_tags #(
  parameter int LINES = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             inval_i,
  input  logic [IDX_W-1:0] inval_idx_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [IDX_W-1:0] lookup_idx_i,
  input  logic [TAG_W-1:0] lookup_tag_i,
  output logic             hit_o
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic inv_here, fill_here;
    assign inv_here  = inval_i && (inval_idx_i == IDX_W'(g));
    assign fill_here = fill_i  && (fill_idx_i  == IDX_W'(g));

    // Priority: reset/flush, then invalidate, then fill.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          valid_q[g] <= 1'b0;
      else if (flush_i)    valid_q[g] <= 1'b0;
      else if (inv_here)   valid_q[g] <= 1'b0;
      else if (fill_here)  valid_q[g] <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tag_q[g] <= '0;
      else if (fill_here)  tag_q[g] <= fill_tag_i;
    end
  end

  assign hit_o = valid_q[lookup_idx_i] && (tag_q[lookup_idx_i] == lookup_tag_i);

  // R8: a flush leaves no valid line behind
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_q == '0));
  // R9: invalidated line is not valid in the next cycle
  a_r9_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inval_i |=> !valid_q[$past(inval_idx_i)]);
  // R10: an unopposed fill leaves its line valid
  a_r10_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && !flush_i && !(inval_i && inval_idx_i == fill_idx_i))
      |=> valid_q[$past(fill_idx_i)]);
endmodule

// File: rtl/commit_redirect_ctrl.sv
module commit_redirect_ctrl
  import redir_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int LINES = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_i,
  input  logic [PC_W-1:0]  exc_vec_i,
  input  logic             viol_i,
  input  logic [PC_W-1:0]  commit_pc_i,
  input  logic [PC_W-1:0]  commit_npc_i,
  input  logic             mispred_i,
  input  logic [PC_W-1:0]  mispred_target_i,
  input  logic             fence_i,
  input  logic             st_stall_i,
  output logic             recover_o,
  output logic [PC_W-1:0]  recover_pc_o,
  output logic             icflush_o,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             inval_i,
  input  logic [IDX_W-1:0] inval_idx_i,
  input  logic [IDX_W-1:0] lookup_idx_i,
  input  logic [TAG_W-1:0] lookup_tag_i,
  output logic             lookup_hit_o
);
  rcause_e cause;

  redir_arbiter u_arb (
    .exc_i      (exc_i),
    .viol_i     (viol_i),
    .mispred_i  (mispred_i),
    .fence_i    (fence_i),
    .st_stall_i (st_stall_i),
    .cause_o    (cause)
  );

  redir_regs #(.PC_W(PC_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cause_i      (cause),
    .exc_vec_i    (exc_vec_i),
    .commit_pc_i  (commit_pc_i),
    .commit_npc_i (commit_npc_i),
    .target_i     (mispred_target_i),
    .recover_o    (recover_o),
    .recover_pc_o (recover_pc_o),
    .flush_o      (icflush_o)
  );

  icache_valid_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_lines (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (icflush_o),
    .inval_i      (inval_i),
    .inval_idx_i  (inval_idx_i),
    .fill_i       (fill_i),
    .fill_idx_i   (fill_idx_i),
    .fill_tag_i   (fill_tag_i),
    .lookup_idx_i (lookup_idx_i),
    .lookup_tag_i (lookup_tag_i),
    .hit_o        (lookup_hit_o)
  );

  // R2: with no accepted event, no pulse in the next cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_i || viol_i || mispred_i || (fence_i && !st_stall_i)) |=> !recover_o);
  // R6: every trap is captured with its own vector
  a_r6_trap_capture: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> (recover_o && recover_pc_o == $past(exc_vec_i) && !icflush_o));
  // R4: unopposed misprediction redirects to its target
  a_r4_mispred_target: assert property (@(posedge clk) disable iff (!rst_n)
    (mispred_i && !exc_i && !viol_i) |=> (recover_o && recover_pc_o == $past(mispred_target_i)));
  // R7: a stalled lone fence changes nothing
  a_r7_stalled_fence: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_i && st_stall_i && !exc_i && !viol_i && !mispred_i) |=> (!recover_o && !icflush_o));
  // R7: a flush never appears without a redirect
  a_r7_flush_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    icflush_o |-> recover_o);
endmodule

// File: tb/tb_commit_redirect_ctrl.sv
module tb_commit_redirect_ctrl;
  localparam int PC_W = 32, LINES = 16, TAG_W = 8, IDX_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exc_i = 0, viol_i = 0, mispred_i = 0, fence_i = 0, st_stall_i = 0;
  logic [PC_W-1:0] exc_vec_i = '0, commit_pc_i = '0, commit_npc_i = '0, mispred_target_i = '0;
  logic recover_o, icflush_o, lookup_hit_o;
  logic [PC_W-1:0] recover_pc_o;
  logic fill_i = 0, inval_i = 0;
  logic [IDX_W-1:0] fill_idx_i = '0, inval_idx_i = '0, lookup_idx_i = '0;
  logic [TAG_W-1:0] fill_tag_i = '0, lookup_tag_i = '0;

  commit_redirect_ctrl #(.PC_W(PC_W), .LINES(LINES), .TAG_W(TAG_W)) dut (.*);

  always #2 clk = ~clk;  // 250 MHz

  typedef struct {
    bit              rec;
    logic [PC_W-1:0] pc;
    bit              fl;
    string           req;
  } exp_t;
  exp_t sb[$];
  exp_t cur;
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, prediction pushed to the scoreboard.
  task automatic cyc(string req, bit e = 0, bit v = 0, bit m = 0, bit f = 0, bit s = 0,
                     logic [PC_W-1:0] ev = 0, logic [PC_W-1:0] cp = 0, logic [PC_W-1:0] tg = 0,
                     bit fi = 0, logic [IDX_W-1:0] fidx = 0, logic [TAG_W-1:0] ftag = 0,
                     bit iv = 0, logic [IDX_W-1:0] iidx = 0);
    exp_t x;
    @(negedge clk);
    exc_i = e; viol_i = v; mispred_i = m; fence_i = f; st_stall_i = s;
    exc_vec_i = ev; commit_pc_i = cp; commit_npc_i = cp + 4; mispred_target_i = tg;
    fill_i = fi; fill_idx_i = fidx; fill_tag_i = ftag; inval_i = iv; inval_idx_i = iidx;
    x.req = req; x.fl = 0;
    x.rec = e | v | m | (f & !s);
    if (e)             x.pc = ev;
    else if (v)        x.pc = cp;
    else if (m)        x.pc = tg;
    else if (f && !s) begin x.pc = cp + 4; x.fl = 1; end
    else               x.pc = 0;
    sb.push_back(x);
  endtask

  // Lookup, sampled in the current (already driven) cycle before its edge.
  task automatic look(string req, logic [IDX_W-1:0] idx, logic [TAG_W-1:0] tag, bit exp);
    lookup_idx_i = idx; lookup_tag_i = tag;
    #1;
    chk(lookup_hit_o == exp, req, "lookup_hit", 32'(lookup_hit_o), 32'(exp));
  endtask

  // Monitor: compares outputs after each edge against the scoreboard.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      chk(recover_o == cur.rec, cur.req, "recover", 32'(recover_o), 32'(cur.rec));
      chk(icflush_o == cur.fl, cur.req, "flush", 32'(icflush_o), 32'(cur.fl));
      if (cur.rec)
        chk(recover_pc_o == cur.pc, cur.req, "recover_pc", recover_pc_o, cur.pc);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(recover_o == 0, "R1", "recover", 32'(recover_o), 0);
    chk(icflush_o == 0, "R1", "flush", 32'(icflush_o), 0);
    look("R1", 4'd5, 8'h00, 0);

    // R10: fills and tag compare
    cyc("R10", .fi(1), .fidx(4'd3), .ftag(8'hA3));
    cyc("R10", .fi(1), .fidx(4'd7), .ftag(8'h17));
    cyc("R10");
    look("R10", 4'd3, 8'hA3, 1);
    look("R10", 4'd3, 8'hA4, 0);
    look("R10", 4'd7, 8'h17, 1);

    // R2/R4/R5/R6: single events, each a one-cycle pulse
    cyc("R4", .m(1), .tg(32'h0000_4000));
    cyc("R2");
    cyc("R5", .v(1), .cp(32'h0000_1230));
    cyc("R2");
    cyc("R6", .e(1), .ev(32'h8000_0100));
    cyc("R6", .e(1), .ev(32'h8000_0200));   // back-to-back trap
    cyc("R2");

    // R3: priority among simultaneous events
    cyc("R3", .e(1), .v(1), .m(1), .f(1), .ev(32'hC000_0000), .cp(32'h500), .tg(32'h900));
    cyc("R3", .v(1), .m(1), .f(1), .cp(32'h600), .tg(32'h900));
    cyc("R3", .m(1), .f(1), .cp(32'h700), .tg(32'hA00));
    cyc("R2");

    // R7: stalled fence is ignored; line 3 stays valid
    cyc("R7", .f(1), .s(1), .cp(32'h2000));
    cyc("R7");
    look("R7", 4'd3, 8'hA3, 1);

    // R9: invalidate, and invalidate beating fill on the same line
    cyc("R9", .iv(1), .iidx(4'd7));
    cyc("R9", .fi(1), .fidx(4'd9), .ftag(8'h99), .iv(1), .iidx(4'd9));
    cyc("R9");
    look("R9", 4'd7, 8'h17, 0);
    look("R9", 4'd9, 8'h99, 0);
    look("R9", 4'd3, 8'hA3, 1);

    // R7/R8: fence pulses flush; fill in the flush cycle loses
    cyc("R7", .f(1), .cp(32'h3000));
    cyc("R8", .fi(1), .fidx(4'd11), .ftag(8'hBB));
    look("R8", 4'd3, 8'hA3, 1);           // flush not yet applied
    cyc("R8");
    look("R8", 4'd3, 8'hA3, 0);
    look("R8", 4'd11, 8'hBB, 0);

    // R10: refill after flush works again
    cyc("R10", .fi(1), .fidx(4'd0), .ftag(8'h42));
    cyc("R10");
    look("R10", 4'd0, 8'h42, 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule